// File: doc/BRIEF.md
# ADC Sample Buffer with Threshold Interrupt

This block stores 16-bit conversion results in a first-in first-out buffer of 1024 entries. The host drains it through a byte-wide read port. Each stored sample takes two host reads: the first returns the low byte and the second returns the high byte. The second read also retires the sample. When the buffer is enabled and holds at least the programmed number of samples, the block raises an interrupt request. The host can then drain a block of samples per interrupt rather than one sample per conversion.

The host programs the threshold in units of two samples, split over two fields. An 8-bit main field carries threshold bits 8..1, and an extension field carries bit 9. The host sees a status byte that holds the empty, threshold, full and overflow flags and echoes the enable and scan settings. A 10-bit depth readback gives the fill level divided by two. A synchronous clear input empties the buffer and drops the sticky overflow flag.

Top module: `adc_sample_buffer`

## Requirements
- R1: Samples leave the buffer in the order they were accepted, with all 16 bits intact, and up to 1024 samples can be held at once.
- R2: The host reads each sample over two `rd_stb` pulses. The first returns bits 7..0 of the oldest sample and leaves that sample in place. The second returns bits 15..8 of the same sample and then removes it.
- R3: A sample offered while 1024 samples are held is dropped, and the overflow flag goes to 1. The flag stays at 1 through later reads and writes until a clear.
- R4: While the buffer is empty, `rd_byte` reads 0xFF. A read strobe in that state removes nothing and does not advance the low/high byte order.
- R5: The threshold in samples is 2 × (256 × `thr_ext` + `thr_main`). The threshold flag is 1 exactly while the fill level is greater than or equal to that value, so it falls as soon as reads bring the level below it.
- R6: `irq` is 1 exactly when the threshold flag is 1 and `fifo_en` is 1.
- R7: A sample offered while `fifo_en` is 0 is not stored and does not set the overflow flag.
- R8: `status_byte` bit 7 is empty, bit 6 is threshold, bit 5 is full, bit 4 is overflow, bit 3 echoes `fifo_en` and bit 2 echoes `scan_en`. Bits 1..0 are 0.
- R9: `depth_rb` equals the fill level divided by two, rounded down. A full buffer reads 512.
- R10: A cycle with `fifo_clr` at 1 leaves the buffer empty, clears overflow and restarts the byte order at the low byte. It overrides any write or read strobe in the same cycle.
- R11: The full flag is 1 exactly while 1024 samples are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Buffer enable; gates writes and the interrupt |
| scan_en | input | 1 | Scan setting, echoed in status |
| fifo_clr | input | 1 | Synchronous clear of contents and flags |
| smp_valid | input | 1 | A conversion result is offered this cycle |
| smp_data | input | 16 | Conversion result |
| thr_main | input | 8 | Threshold bits 8..1 |
| thr_ext | input | 1 | Threshold bit 9 |
| rd_stb | input | 1 | Host byte read strobe |
| rd_byte | output | 8 | Byte returned to the host for the current read |
| status_byte | output | 8 | Flags and settings, as laid out in R8 |
| depth_rb | output | 10 | Fill level divided by two |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that `fifo_clr` and `rd_stb` are single-cycle register accesses. They also assume that threshold fields stay unchanged while the fill level is being compared against them. The stimulus drives every input on the falling edge and holds it for exactly one rising edge. It changes the threshold fields only between phases. It issues `rd_stb` at most once per cycle, so the byte order can be followed read by read. Writes are offered back to back when the buffer is filled to capacity. In that run the threshold crossing, the full boundary and the dropped sample all fall on known cycles.

// File: rtl/asb_pkg.sv
package asb_pkg;

  typedef struct packed {
    logic       empty;
    logic       thr;
    logic       full;
    logic       ovf;
    logic       en;
    logic       scan;
    logic [1:0] zero;
  } asb_status_t;

endpackage

// File: rtl/asb_store.sv
module asb_store #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_req,
  input  logic          pop,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] head_data,
  output logic [AW:0]   count,
  output logic          full,
  output logic          empty,
  output logic          ovf
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          accept, ovf_set;

  assign full      = (count == DEPTH_C);
  assign empty     = (count == '0);
  assign accept    = push_req && !full && !clr;
  assign ovf_set   = push_req && full && !clr;
  assign head_data = mem[rp];

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (accept) wp <= wp + 1'b1;
      if (pop)    rp <= rp + 1'b1;
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (ovf_set) ovf <= 1'b1;
    end
  end

  // R1: level never exceeds capacity
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);

  // R3: write into a full buffer is dropped and flags overflow
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop && !clr) |=> (full && ovf));

  // R3: overflow is sticky until clear
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);

  // R10: clear leaves an empty buffer without overflow
  p_clr_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !ovf));

  // R4: the read side never retires from an empty buffer
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/asb_hostport.sv
module asb_hostport #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rd_stb,
  input  logic          empty,
  input  logic [DW-1:0] head_data,
  output logic [7:0]    rd_byte,
  output logic          pop
);
  logic hi_phase;
  logic rd_live;

  assign rd_live = rd_stb && !empty && !clr;
  assign pop     = rd_live && hi_phase;

  always_comb begin
    if (empty)         rd_byte = 8'hFF;
    else if (hi_phase) rd_byte = head_data[15:8];
    else               rd_byte = head_data[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_phase <= 1'b0;
    else if (clr)     hi_phase <= 1'b0;
    else if (rd_live) hi_phase <= !hi_phase;
  end

  // R2: a low-byte read moves the port to the high byte
  p_byte_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_live && !hi_phase) |=> hi_phase);

  // R4: a strobe on an empty buffer leaves the byte order unchanged
  p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && empty && !clr) |=> $stable(hi_phase));
endmodule

// File: rtl/asb_level.sv
module asb_level #(
  parameter int AW = 10
) (
  input  logic          enable,
  input  logic [AW:0]   count,
  input  logic [7:0]    thr_main,
  input  logic [AW-10:0] thr_ext,
  output logic          thr_flag,
  output logic          irq,
  output logic [AW-1:0] depth_rb
);
  // threshold in samples: two per programmed unit
  function automatic logic [AW:0] thr_samples(input logic [AW-10:0] ext,
                                              input logic [7:0] main);
    return {1'b0, ext, main, 1'b0};
  endfunction

  // depth readback in units of two samples
  function automatic logic [AW-1:0] depth_half(input logic [AW:0] lvl);
    return lvl[AW:1];
  endfunction

  assign thr_flag = (count >= thr_samples(thr_ext, thr_main));
  assign irq      = thr_flag && enable;
  assign depth_rb = depth_half(count);
endmodule

// File: rtl/adc_sample_buffer.sv
module adc_sample_buffer #(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fifo_en,
  input  logic        scan_en,
  input  logic        fifo_clr,
  input  logic        smp_valid,
  input  logic [15:0] smp_data,
  input  logic [7:0]  thr_main,
  input  logic [AW-10:0] thr_ext,
  input  logic        rd_stb,
  output logic [7:0]  rd_byte,
  output logic [7:0]  status_byte,
  output logic [AW-1:0] depth_rb,
  output logic        irq
);
  import asb_pkg::*;
  localparam int DW = 16;

  logic [DW-1:0] head_data;
  logic [AW:0]   count;
  logic          full, empty, ovf, pop, thr_flag, push_req;
  asb_status_t   st;

  assign push_req = smp_valid && fifo_en;

  asb_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push_req(push_req), .pop(pop),
    .wr_data(smp_data), .head_data(head_data), .count(count),
    .full(full), .empty(empty), .ovf(ovf)
  );

  asb_hostport #(.DW(DW)) u_port (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .rd_stb(rd_stb), .empty(empty),
    .head_data(head_data), .rd_byte(rd_byte), .pop(pop)
  );

  asb_level #(.AW(AW)) u_level (
    .enable(fifo_en), .count(count), .thr_main(thr_main), .thr_ext(thr_ext),
    .thr_flag(thr_flag), .irq(irq), .depth_rb(depth_rb)
  );

  always_comb begin
    st.empty = empty;
    st.thr   = thr_flag;
    st.full  = full;
    st.ovf   = ovf;
    st.en    = fifo_en;
    st.scan  = scan_en;
    st.zero  = 2'b00;
  end
  assign status_byte = st;

  // R6: no request while the buffer is disabled
  p_irq_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fifo_en);

  // R7: a disabled write leaves the level unchanged
  p_disabled_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !fifo_en && !pop && !fifo_clr) |=> $stable(count));
endmodule

// File: tb/adc_sample_buffer_tb_top.sv
module adc_sample_buffer_tb_top;
  localparam int CLK_P = 10;
  localparam int CAP = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, scan_en = 1'b0, fifo_clr = 1'b0, smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic [7:0] thr_main = '0;
  logic [0:0] thr_ext = '0;
  logic rd_stb = 1'b0;
  logic [7:0] rd_byte, status_byte;
  logic [9:0] depth_rb;
  logic irq;

  int checks = 0, errors = 0;
  logic [15:0] sb_q[$];
  bit ovf_m = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_sample_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .scan_en(scan_en),
    .fifo_clr(fifo_clr), .smp_valid(smp_valid), .smp_data(smp_data),
    .thr_main(thr_main), .thr_ext(thr_ext), .rd_stb(rd_stb),
    .rd_byte(rd_byte), .status_byte(status_byte), .depth_rb(depth_rb), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int thr_model();
    return 2 * (256 * int'(thr_ext) + int'(thr_main));
  endfunction

  function automatic int status_model();
    int n = sb_q.size();
    return {n == 0, n >= thr_model(), n == CAP, ovf_m, fifo_en, scan_en, 2'b00};
  endfunction

  // driver: offer one sample and record what should be stored
  task automatic push(input logic [15:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d;
    if (fifo_en) begin
      if (sb_q.size() < CAP) sb_q.push_back(d);
      else ovf_m = 1;
    end
    @(posedge clk); #1 smp_valid = 1'b0;
  endtask

  task automatic strobe_read(output logic [7:0] b);
    @(negedge clk);
    rd_stb = 1'b1; b = rd_byte;
    @(posedge clk); #1 rd_stb = 1'b0;
  endtask

  // monitor: two reads per sample, compared against the scoreboard
  task automatic read_sample(input string tag);
    logic [7:0] lo, hi;
    logic [15:0] exp;
    exp = sb_q.pop_front();
    strobe_read(lo);
    strobe_read(hi);
    check({tag, " R2 low byte"}, lo, exp[7:0]);
    check({tag, " R1 high byte"}, hi, exp[15:8]);
  endtask

  task automatic check_status(input string tag);
    @(negedge clk);
    check({tag, " R8 status"}, status_byte, status_model());
    check({tag, " R9 depth"}, depth_rb, sb_q.size() / 2);
    check({tag, " R6 irq"}, irq, (fifo_en && sb_q.size() >= thr_model()) ? 1 : 0);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    fifo_clr = 1'b1; smp_valid = 1'b1; smp_data = 16'hDEAD; rd_stb = 1'b1;
    @(posedge clk); #1;
    fifo_clr = 1'b0; smp_valid = 1'b0; rd_stb = 1'b0;
    sb_q.delete(); ovf_m = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_status("reset");

    // R4: empty read returns 0xFF and does not disturb byte order
    strobe_read(b);
    check("R4 empty read", b, 8'hFF);

    // R7: disabled writes are ignored
    push(16'h1234);
    check_status("R7 disabled write");

    fifo_en = 1'b1; scan_en = 1'b1; thr_main = 8'd2;
    push(16'hA55A); push(16'h0001); push(16'hFF00);
    check_status("R5 below threshold");
    push(16'h8000);
    check_status("R5 at threshold");
    fifo_en = 1'b0;
    check_status("R6 irq gated");
    fifo_en = 1'b1;
    read_sample("R2 seq0");
    check_status("R5 dropped below");
    read_sample("seq1"); read_sample("seq2"); read_sample("seq3");
    strobe_read(b);
    check("R4 empty after drain", b, 8'hFF);
    check_status("drained");

    // R10: clear mid-sample restarts byte order and ignores same-cycle write
    push(16'hBEEF); push(16'hCAFE);
    strobe_read(b);
    check("R2 low before clear", b, 8'hEF);
    pulse_clr();
    check_status("R10 after clear");
    push(16'h4321);
    read_sample("R10 order restarted");

    // R11, R3, R5 with the extension bit: fill to capacity
    thr_ext = 1'b1; thr_main = 8'd0;
    for (int i = 0; i < CAP; i++) begin
      push(16'((i * 40503) ^ 16'h5A5A));
      if (i == 510) check_status("R5 ext 511");
      if (i == 511) check_status("R5 ext 512");
    end
    check_status("R11 full");
    push(16'h7777);
    check_status("R3 overflow");
    for (int i = 0; i < CAP; i++) begin
      read_sample("R1 drain");
      if (i == 512) check_status("R3 sticky mid drain");
    end
    check_status("R3 sticky empty");
    pulse_clr();
    check_status("R10 clears overflow");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule